// File: doc/BRIEF.md
# Operating Mode Sequencer

This block holds the operating mode of a small microcontroller and turns software requests and wake events into oscillator enables, a CPU clock select and two halt flags. Software requests arrive as single-cycle write strobes, each with a data bit where one is needed. The current mode decides which request is honoured and which wake source can end a low-power state. The oscillators, their warm-up timers and the CPU are outside the block. Only their enable and halt lines are driven here.

There are four run modes: high oscillator only, both oscillators with the CPU on the high clock, both oscillators with the CPU on the low clock, and low oscillator only. Each run mode has an idle state in which the CPU halts and peripherals keep running, and an interrupt ends it. From the high-only and low-only run modes a timer-halt state halts everything except the time-base timer, and a falling edge of the timer clock ends it. A stop state turns off both oscillators, and only the stop-release pin ends it. The block returns to the run mode that was active when stop was entered.

Top module: `opmode_seq`

## Requirements
- R1: While `rst_n` is low, `mode_o` reads 11, `cpu_halt` and `per_halt` are 1, `hosc_en` is 1, and `losc_en` and `clk_sel` are 0. After release the mode is 0.
- R2: Mode codes are 0 high-only run, 1 dual run, 2 dual slow run, 3 low-only run, 4 to 7 the idle state of run mode 0 to 3, 8 high-timer-halt, 9 low-timer-halt and 10 stop. Oscillator enables follow the clocks each mode uses. `clk_sel` is 1 only when the CPU clock is the low one. `cpu_halt` is 1 in codes 4 to 10. `per_halt` is 1 in codes 8 to 10.
- R3: In mode 0, writing low-oscillator 1 moves to mode 1. In mode 1, writing it 0 moves to mode 0.
- R4: In mode 1, writing clock-select 1 moves to mode 2, and writing 0 in mode 2 moves back. In mode 2, writing high-oscillator 0 moves to mode 3, and writing 1 in mode 3 moves back.
- R5: An idle write in run mode m (0 to 3) enters mode m+4. `irq` high in mode m+4 returns to m one cycle later.
- R6: A timer-halt write enters mode 8 from mode 0 and mode 9 from mode 3, and is ignored in modes 1 and 2. Modes 8 and 9 leave, to 0 and 3, only in the cycle after `tbt_clk` was sampled high and is then sampled low.
- R7: A stop write from any run mode enters mode 10 with both oscillators off. `stop_pin` high there returns to the run mode stop was entered from. `irq` and timer edges do not end stop.
- R8: When several strobes arrive together, only the highest one present counts, in the order stop, timer-halt, idle, clock-select, high-oscillator, low-oscillator. If that one is illegal in the current mode, nothing changes.
- R9: Writes are ignored outside run modes. A wake input has no effect outside the modes it ends.
- R10: `err_o` is sticky and set only if the mode register holds an undefined code. It stays 0 under legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_idle | input | 1 | Idle request strobe |
| wr_tmr_halt | input | 1 | Timer-halt request strobe |
| wr_stop | input | 1 | Stop request strobe |
| wr_clk_sel | input | 1 | Clock-select write strobe |
| clk_sel_d | input | 1 | Clock-select data (1 = low clock) |
| wr_hosc | input | 1 | High-oscillator enable write strobe |
| hosc_d | input | 1 | High-oscillator enable data |
| wr_losc | input | 1 | Low-oscillator enable write strobe |
| losc_d | input | 1 | Low-oscillator enable data |
| irq | input | 1 | Interrupt request |
| tbt_clk | input | 1 | Selected time-base timer clock |
| stop_pin | input | 1 | Stop release pin |
| mode_o | output | 4 | Current mode code |
| hosc_en | output | 1 | High oscillator enable |
| losc_en | output | 1 | Low oscillator enable |
| clk_sel | output | 1 | CPU clock select (1 = low clock) |
| cpu_halt | output | 1 | CPU halted |
| per_halt | output | 1 | Peripherals other than the time-base timer halted |
| err_o | output | 1 | Sticky undefined-mode flag |

## Verification
The assertions assume that every input is synchronous to `clk`, that `tbt_clk` is a slow level that is already synchronised, and that `stop_pin` and `irq` are levels sampled at the clock edge. The stimulus changes all inputs only on the falling clock edge and holds each table row for exactly one rising edge. A timer edge therefore appears as one row with `tbt_clk` high followed by one row with it low. A walk through the table reaches every legal transition and the priority and ignore cases. Directed steps then cover reset, both while it is held and in the middle of operation.

// File: rtl/opmode_seq.sv
module opmode_seq #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_idle,
  input  logic              wr_tmr_halt,
  input  logic              wr_stop,
  input  logic              wr_clk_sel,
  input  logic              clk_sel_d,
  input  logic              wr_hosc,
  input  logic              hosc_d,
  input  logic              wr_losc,
  input  logic              losc_d,
  input  logic              irq,
  input  logic              tbt_clk,
  input  logic              stop_pin,
  output logic [MODE_W-1:0] mode_o,
  output logic              hosc_en,
  output logic              losc_en,
  output logic              clk_sel,
  output logic              cpu_halt,
  output logic              per_halt,
  output logic              err_o
);
  localparam logic [MODE_W-1:0] M_HRUN  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_DRUN  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_DSLOW = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_LRUN  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_HIDLE = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_DIDLE = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_DSLP  = MODE_W'(6);
  localparam logic [MODE_W-1:0] M_LSLP  = MODE_W'(7);
  localparam logic [MODE_W-1:0] M_HTMR  = MODE_W'(8);
  localparam logic [MODE_W-1:0] M_LTMR  = MODE_W'(9);
  localparam logic [MODE_W-1:0] M_STOP  = MODE_W'(10);
  localparam logic [MODE_W-1:0] M_RST   = MODE_W'(11);
  localparam logic [MODE_W-1:0] IDLE_OFS = MODE_W'(4);

  logic [MODE_W-1:0] cur, nxt, ret_q, ret_d;
  logic              tbt_q, err_q;

  wire run_mode  = (cur <= M_LRUN);
  wire idle_mode = (cur >= M_HIDLE) && (cur <= M_LSLP);
  wire tbt_fall  = tbt_q & ~tbt_clk;
  wire bad_code  = (cur > M_STOP);

  function automatic logic [MODE_W-1:0] cfg_next(input logic [MODE_W-1:0] m);
    logic [MODE_W-1:0] r;
    r = m;
    if (wr_clk_sel) begin
      if (m == M_DRUN && clk_sel_d)        r = M_DSLOW;
      else if (m == M_DSLOW && !clk_sel_d) r = M_DRUN;
    end else if (wr_hosc) begin
      if (m == M_DSLOW && !hosc_d)         r = M_LRUN;
      else if (m == M_LRUN && hosc_d)      r = M_DSLOW;
    end else if (wr_losc) begin
      if (m == M_HRUN && losc_d)           r = M_DRUN;
      else if (m == M_DRUN && !losc_d)     r = M_HRUN;
    end
    return r;
  endfunction

  always_comb begin
    nxt   = cur;
    ret_d = ret_q;
    if (run_mode) begin
      if (wr_stop) begin
        nxt   = M_STOP;
        ret_d = cur;
      end else if (wr_tmr_halt) begin
        if (cur == M_HRUN)      nxt = M_HTMR;
        else if (cur == M_LRUN) nxt = M_LTMR;
      end else if (wr_idle) begin
        nxt = cur + IDLE_OFS;
      end else begin
        nxt = cfg_next(cur);
      end
    end else if (idle_mode) begin
      if (irq) nxt = cur - IDLE_OFS;
    end else if (cur == M_HTMR) begin
      if (tbt_fall) nxt = M_HRUN;
    end else if (cur == M_LTMR) begin
      if (tbt_fall) nxt = M_LRUN;
    end else if (cur == M_STOP) begin
      if (stop_pin) nxt = ret_q;
    end else begin
      nxt = M_HRUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= M_HRUN;
      ret_q <= M_HRUN;
      tbt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cur   <= nxt;
      ret_q <= ret_d;
      tbt_q <= tbt_clk;
      err_q <= err_q | bad_code;
    end
  end

  logic h, l, s;
  always_comb begin
    h = 1'b1; l = 1'b0; s = 1'b0;
    case (cur)
      M_HRUN, M_HIDLE, M_HTMR: begin h = 1'b1; l = 1'b0; s = 1'b0; end
      M_DRUN, M_DIDLE:         begin h = 1'b1; l = 1'b1; s = 1'b0; end
      M_DSLOW, M_DSLP:         begin h = 1'b1; l = 1'b1; s = 1'b1; end
      M_LRUN, M_LSLP, M_LTMR:  begin h = 1'b0; l = 1'b1; s = 1'b1; end
      M_STOP:                  begin h = 1'b0; l = 1'b0; s = 1'b0; end
      default:                 begin h = 1'b1; l = 1'b0; s = 1'b0; end
    endcase
  end

  assign mode_o   = rst_n ? cur : M_RST;
  assign hosc_en  = rst_n ? h : 1'b1;
  assign losc_en  = rst_n & l;
  assign clk_sel  = rst_n & s;
  assign cpu_halt = ~rst_n | ~run_mode;
  assign per_halt = ~rst_n | (cur >= M_HTMR);
  assign err_o    = err_q;

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == M_STOP && !stop_pin) |=> (cur == M_STOP));

  // R5
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode && irq) |=> (cur == $past(cur) - IDLE_OFS));

  // R6
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur == M_HTMR || cur == M_LTMR) && !tbt_fall) |=> $stable(cur));

  // R8
  stop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && wr_stop) |=> (cur == M_STOP && !hosc_en && !losc_en));

  // R2
  halt_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_halt |-> cpu_halt);

  // R4
  low_only_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hosc_en && losc_en) |-> clk_sel);
endmodule

// File: tb/opmode_seq_tb_top.sv
module opmode_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_idle = 0, wr_tmr_halt = 0, wr_stop = 0, wr_clk_sel = 0, clk_sel_d = 0;
  logic wr_hosc = 0, hosc_d = 0, wr_losc = 0, losc_d = 0, irq = 0, tbt_clk = 0, stop_pin = 0;
  logic [3:0] mode_o;
  logic hosc_en, losc_en, clk_sel, cpu_halt, per_halt, err_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opmode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_idle(wr_idle), .wr_tmr_halt(wr_tmr_halt),
    .wr_stop(wr_stop), .wr_clk_sel(wr_clk_sel), .clk_sel_d(clk_sel_d),
    .wr_hosc(wr_hosc), .hosc_d(hosc_d), .wr_losc(wr_losc), .losc_d(losc_d),
    .irq(irq), .tbt_clk(tbt_clk), .stop_pin(stop_pin), .mode_o(mode_o),
    .hosc_en(hosc_en), .losc_en(losc_en), .clk_sel(clk_sel),
    .cpu_halt(cpu_halt), .per_halt(per_halt), .err_o(err_o)
  );

  localparam logic [11:0] I_NONE  = 12'h000;
  localparam logic [11:0] I_IDLE  = 12'h800;
  localparam logic [11:0] I_TGH   = 12'h400;
  localparam logic [11:0] I_STOP  = 12'h200;
  localparam logic [11:0] I_SYS1  = 12'h180;
  localparam logic [11:0] I_SYS0  = 12'h100;
  localparam logic [11:0] I_XEN1  = 12'h060;
  localparam logic [11:0] I_XEN0  = 12'h040;
  localparam logic [11:0] I_XTEN1 = 12'h018;
  localparam logic [11:0] I_XTEN0 = 12'h010;
  localparam logic [11:0] I_IRQ   = 12'h004;
  localparam logic [11:0] I_SREL  = 12'h002;
  localparam logic [11:0] I_TBT   = 12'h001;

  localparam int NV = 54;
  // each row: {requirement, stimulus, expected mode after one rising edge}
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, I_NONE, 4'd0},
    {4'd5, I_IDLE, 4'd4},            // R5
    {4'd5, I_NONE, 4'd4},
    {4'd5, I_IRQ, 4'd0},
    {4'd6, I_TGH, 4'd8},             // R6
    {4'd9, I_IRQ, 4'd8},             // R9
    {4'd6, I_TBT, 4'd8},
    {4'd6, I_NONE, 4'd0},
    {4'd7, I_STOP, 4'd10},           // R7
    {4'd7, I_IRQ, 4'd10},
    {4'd7, I_SREL, 4'd0},
    {4'd3, I_XTEN1, 4'd1},           // R3
    {4'd3, I_XTEN0, 4'd0},
    {4'd3, I_XTEN1, 4'd1},
    {4'd5, I_IDLE, 4'd5},
    {4'd5, I_IRQ, 4'd1},
    {4'd6, I_TGH, 4'd1},
    {4'd7, I_STOP, 4'd10},
    {4'd7, I_SREL, 4'd1},
    {4'd4, I_SYS1, 4'd2},            // R4
    {4'd4, I_SYS0, 4'd1},
    {4'd4, I_SYS1, 4'd2},
    {4'd5, I_IDLE, 4'd6},
    {4'd5, I_IRQ, 4'd2},
    {4'd7, I_STOP, 4'd10},
    {4'd7, I_SREL, 4'd2},
    {4'd4, I_XEN0, 4'd3},
    {4'd5, I_IDLE, 4'd7},
    {4'd5, I_IRQ, 4'd3},
    {4'd6, I_TGH, 4'd9},
    {4'd6, I_TBT, 4'd9},
    {4'd6, I_NONE, 4'd3},
    {4'd7, I_STOP, 4'd10},
    {4'd7, I_SREL, 4'd3},
    {4'd8, I_XTEN0, 4'd3},           // R8
    {4'd8, I_SYS0, 4'd3},
    {4'd4, I_XEN1, 4'd2},
    {4'd8, I_XEN0 | I_SYS0, 4'd1},
    {4'd8, I_STOP | I_IDLE, 4'd10},
    {4'd7, I_SREL, 4'd1},
    {4'd8, I_TGH | I_IDLE, 4'd1},
    {4'd8, I_IDLE | I_XTEN0, 4'd5},
    {4'd5, I_IRQ, 4'd1},
    {4'd3, I_XTEN0, 4'd0},
    {4'd8, I_SYS1, 4'd0},
    {4'd8, I_XEN0, 4'd0},
    {4'd5, I_IDLE, 4'd4},
    {4'd9, I_XTEN1, 4'd4},
    {4'd5, I_IRQ, 4'd0},
    {4'd9, I_SREL, 4'd0},
    {4'd5, I_IDLE, 4'd4},
    {4'd9, I_TBT, 4'd4},
    {4'd9, I_NONE, 4'd4},
    {4'd5, I_IRQ, 4'd0}
  };

  task automatic chk(input logic ok, input int req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_out(input logic [3:0] m);
    logic h, l, s, c, p;
    h = (m == 0 || m == 1 || m == 2 || m == 4 || m == 5 || m == 6 || m == 8 || m == 11);
    l = (m == 1 || m == 2 || m == 3 || m == 5 || m == 6 || m == 7 || m == 9);
    s = (m == 2 || m == 3 || m == 6 || m == 7 || m == 9);
    c = (m >= 4);
    p = (m >= 8);
    return {h, l, s, c, p};
  endfunction

  task automatic check_mode(input int req, input logic [3:0] m);
    logic [4:0] got;
    got = {hosc_en, losc_en, clk_sel, cpu_halt, per_halt};
    chk(mode_o == m, req, "mode", {4'd0, mode_o}, {4'd0, m});
    chk(got == exp_out(m), req, "outputs", {3'd0, got}, {3'd0, exp_out(m)});
  endtask

  task automatic apply(input logic [11:0] s);
    {wr_idle, wr_tmr_halt, wr_stop, wr_clk_sel, clk_sel_d, wr_hosc, hosc_d,
     wr_losc, losc_d, irq, stop_pin, tbt_clk} = s;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state held
    check_mode(1, 4'd11);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_mode(1, 4'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][15:4]);
      @(posedge clk); #1;
      check_mode(int'(VEC[i][19:16]), VEC[i][3:0]);
    end
    @(negedge clk);
    apply(I_NONE);

    // R10: no error flag after a full legal walk
    chk(err_o == 1'b0, 10, "err", {7'd0, err_o}, 8'd0);

    // R1: reset in the middle of a slow mode
    apply(I_XTEN1);
    @(negedge clk); apply(I_SYS1);
    @(negedge clk); apply(I_NONE);
    check_mode(4, 4'd2);
    rst_n = 1'b0;
    #1;
    check_mode(1, 4'd11);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_mode(1, 4'd0);
    chk(err_o == 1'b0, 10, "err after reset", {7'd0, err_o}, 8'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule